// File: doc/BRIEF.md
# Key-Protected Windowed Independent Watchdog

This block is a watchdog timer whose time base is a separate low-speed clock. Software controls it through a small register bank: a key register that accepts coded commands, a prescaler code, a 12-bit reload value, a status word with two busy flags, and a window limit. Once started, a 12-bit down-counter steps once per prescaled low-speed period. When that counter expires, the block emits a one-cycle reset request for the system. Software prevents this by writing the feed key in time. That write refills the counter from the reload value.

The prescaler, reload and window registers accept writes only after the unlock key has been written. Any other key value locks them again. The start command is one-way: no register write can stop a running counter, and only the block reset returns it to the stopped state. A window limit below the all-ones value turns an early feed into an immediate reset request. A debug-freeze input holds the counter still. The low-speed clock is brought into the bus clock domain by a short synchronizer chain. Its rising edges become single-cycle ticks. New prescaler and reload values move into the counting logic on the next such tick, and the busy flags show that a transfer is pending.

Top module: `indep_watchdog`

## Requirements
- R1: After reset, a read of the prescaler register (offset 0x04, bits 2:0) returns 0, the reload register (offset 0x08, bits 11:0) returns 0xFFF, the window register (offset 0x10, bits 11:0) returns 0xFFF, and the status register (offset 0x0C) returns 0.
- R2: Writes to the prescaler, reload or window registers take effect only after 0x00005555 has been written to the key register (offset 0x00). While the bank is locked such writes are ignored.
- R3: Writing any 32-bit key value other than 0x00005555 to the key register locks the bank again.
- R4: Writing 0x0000CCCC to the key register starts the counter from the reload value. If it is not fed, one reset request is issued on the tick of the (reload+1)×divisor-th low-speed rising edge after the start.
- R5: Prescaler code c in 0..6 selects a divisor of 4·2^c (4, 8, 16, 32, 64, 128, 256). Code 7 also selects 256.
- R6: Writing 0x0000AACA is not a feed; only 0x0000AAAA is. A feed refills the counter from the reload value and restarts the prescaler, so the next expiry is a full timeout after the feed.
- R7: Once started, the counter keeps running whatever is written to the key register. Only the block reset stops it.
- R8: Status bit 0 (prescaler busy) and bit 1 (reload busy) are set by an accepted write to the matching register. Each clears once the value has been transferred on the next low-speed tick.
- R9: If the counter is above the window value when a feed arrives, a reset request is issued in the cycle after the write. A feed with the counter at or below the window value is accepted.
- R10: While dbg_freeze is high the counter does not step, and the timeout is extended by the frozen low-speed periods.
- R11: wdg_reset is a pulse exactly one clock cycle wide.
- R12: The block reset stops the counter and restores register defaults, and no reset request is issued while the counter is stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all state is updated on its rising edge |
| rst | input | 1 | Synchronous active-high block reset |
| ls_clk | input | 1 | Low-speed time-base clock, asynchronous to clk |
| dbg_freeze | input | 1 | High holds the counter still |
| wr_en | input | 1 | Register write strobe for one clk cycle |
| addr | input | 5 | Byte offset of the register accessed |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr, combinational |
| wdg_reset | output | 1 | One-cycle system reset request |

## Verification
Register readback is valid in the cycle after the write. A busy flag is cleared about three clk cycles after the first low-speed rising edge that follows the write, once the edge has passed the two synchronizer stages and the edge detector. A timeout request appears three clk cycles after the expiring low-speed edge, and an early-feed request appears one cycle after the feed write. The bench counts low-speed rising edges itself and issues every write a few cycles after an edge, so each tick is clearly before or after it. Each expected reset request is queued with the low-speed edge index it must carry. The monitor pairs every pulse with the queued index, and the eight-cycle low-speed period is much longer than the three-cycle latency, so that comparison is exact.

// File: rtl/iwdg_pkg.sv
package iwdg_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 5;
    localparam int CNT_W  = 12;
    localparam int CODE_W = 3;
    localparam int PRE_W  = 8;
    localparam int STAT_W = 2;

    localparam logic [DATA_W-1:0] KEY_UNLOCK = 32'h0000_5555;
    localparam logic [DATA_W-1:0] KEY_START  = 32'h0000_CCCC;
    localparam logic [DATA_W-1:0] KEY_FEED   = 32'h0000_AAAA;

    localparam logic [ADDR_W-1:0] OFF_KEY  = 5'h00;
    localparam logic [ADDR_W-1:0] OFF_PRE  = 5'h04;
    localparam logic [ADDR_W-1:0] OFF_RLD  = 5'h08;
    localparam logic [ADDR_W-1:0] OFF_STAT = 5'h0C;
    localparam logic [ADDR_W-1:0] OFF_WIN  = 5'h10;

    localparam logic [CNT_W-1:0]  CNT_ALL  = '1;
    localparam logic [CODE_W-1:0] CODE_TOP = 3'd6;

    // Status bit positions
    localparam int BIT_PRE_BUSY = 0;
    localparam int BIT_RLD_BUSY = 1;

    typedef enum logic [2:0] {
        SEL_KEY,
        SEL_PRE,
        SEL_RLD,
        SEL_STAT,
        SEL_WIN,
        SEL_NONE
    } sel_e;

    typedef enum logic [1:0] {
        CMD_IDLE,
        CMD_START,
        CMD_FEED
    } cmd_e;

    // Configuration seen by the counting logic
    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic [CNT_W-1:0]  reload;
        logic [CNT_W-1:0]  window;
    } cfg_t;

    function automatic sel_e decode_sel(input logic [ADDR_W-1:0] a);
        case (a)
            OFF_KEY:  return SEL_KEY;
            OFF_PRE:  return SEL_PRE;
            OFF_RLD:  return SEL_RLD;
            OFF_STAT: return SEL_STAT;
            OFF_WIN:  return SEL_WIN;
            default:  return SEL_NONE;
        endcase
    endfunction

    // Last value of the prescaler count before it wraps (divisor - 1)
    function automatic logic [PRE_W-1:0] prescale_last(input logic [CODE_W-1:0] code);
        if (code >= CODE_TOP) begin
            return '1;
        end
        return PRE_W'((32'd4 << code) - 32'd1);
    endfunction

    function automatic cmd_e key_to_cmd(input logic [DATA_W-1:0] k);
        if (k == KEY_START) begin
            return CMD_START;
        end
        if (k == KEY_FEED) begin
            return CMD_FEED;
        end
        return CMD_IDLE;
    endfunction

endpackage

// File: rtl/iwdg_edge_sync.sv
module iwdg_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise
);
    // chain[0..STAGES-1] synchronize, chain[STAGES] holds the previous value
    logic [STAGES:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-1:0], async_in};
        end
    end

    assign rise = chain[STAGES-1] & ~chain[STAGES];

endmodule

// File: rtl/iwdg_regs.sv
module iwdg_regs
    import iwdg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              ls_tick,
    output cmd_e              cmd,
    output cfg_t              cfg,
    output logic              unlocked,
    output logic [CODE_W-1:0] code_shadow,
    output logic [STAT_W-1:0] busy,
    output logic [DATA_W-1:0] rdata
);
    sel_e             sel;
    logic [CNT_W-1:0] rld_shadow;
    logic             wr_key;
    logic             wr_pre;
    logic             wr_rld;
    logic             wr_win;

    assign sel    = decode_sel(addr);
    assign wr_key = wr_en && (sel == SEL_KEY);
    assign wr_pre = wr_en && (sel == SEL_PRE) && unlocked;
    assign wr_rld = wr_en && (sel == SEL_RLD) && unlocked;
    assign wr_win = wr_en && (sel == SEL_WIN) && unlocked;
    assign cmd    = wr_key ? key_to_cmd(wdata) : CMD_IDLE;

    always_ff @(posedge clk) begin
        if (rst) begin
            unlocked    <= 1'b0;
            code_shadow <= '0;
            rld_shadow  <= CNT_ALL;
            busy        <= '0;
            cfg.code    <= '0;
            cfg.reload  <= CNT_ALL;
            cfg.window  <= CNT_ALL;
        end else begin
            if (wr_key) begin
                unlocked <= (wdata == KEY_UNLOCK);
            end
            // prescaler: shadow, then moved across on the next low-speed tick
            if (wr_pre) begin
                code_shadow        <= wdata[CODE_W-1:0];
                busy[BIT_PRE_BUSY] <= 1'b1;
            end else if (ls_tick && busy[BIT_PRE_BUSY]) begin
                cfg.code           <= code_shadow;
                busy[BIT_PRE_BUSY] <= 1'b0;
            end
            // reload: same transfer scheme
            if (wr_rld) begin
                rld_shadow         <= wdata[CNT_W-1:0];
                busy[BIT_RLD_BUSY] <= 1'b1;
            end else if (ls_tick && busy[BIT_RLD_BUSY]) begin
                cfg.reload         <= rld_shadow;
                busy[BIT_RLD_BUSY] <= 1'b0;
            end
            if (wr_win) begin
                cfg.window <= wdata[CNT_W-1:0];
            end
        end
    end

    always_comb begin
        rdata = '0;
        case (sel)
            SEL_PRE:  rdata = {{(DATA_W-CODE_W){1'b0}}, code_shadow};
            SEL_RLD:  rdata = {{(DATA_W-CNT_W){1'b0}}, rld_shadow};
            SEL_STAT: rdata = {{(DATA_W-STAT_W){1'b0}}, busy};
            SEL_WIN:  rdata = {{(DATA_W-CNT_W){1'b0}}, cfg.window};
            default:  rdata = '0;
        endcase
    end

endmodule

// File: rtl/iwdg_core.sv
module iwdg_core
    import iwdg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ls_tick,
    input  logic             freeze,
    input  cmd_e             cmd,
    input  cfg_t             cfg,
    output logic             running,
    output logic [CNT_W-1:0] count,
    output logic             fire
);
    logic [PRE_W-1:0] pre_q;
    logic             step;
    logic             wrap;
    logic             expire;
    logic             early;
    logic             fire_d;

    assign step   = running && ls_tick && !freeze;
    assign wrap   = step && (pre_q >= prescale_last(cfg.code));
    assign early  = running && (cmd == CMD_FEED) && (count > cfg.window);
    assign expire = wrap && (count == '0) && (cmd != CMD_FEED);
    assign fire_d = early || expire;

    always_ff @(posedge clk) begin
        if (rst) begin
            running <= 1'b0;
            count   <= CNT_ALL;
            pre_q   <= '0;
            fire    <= 1'b0;
        end else begin
            fire <= fire_d && !fire;
            if ((cmd == CMD_START) && !running) begin
                running <= 1'b1;
                count   <= cfg.reload;
                pre_q   <= '0;
            end else if (cmd == CMD_FEED) begin
                count <= cfg.reload;
                pre_q <= '0;
            end else if (step) begin
                if (wrap) begin
                    pre_q <= '0;
                    count <= (count == '0) ? cfg.reload : count - CNT_W'(1);
                end else begin
                    pre_q <= pre_q + PRE_W'(1);
                end
            end
        end
    end

endmodule

// File: rtl/indep_watchdog.sv
module indep_watchdog
    import iwdg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ls_clk,
    input  logic              dbg_freeze,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              wdg_reset
);
    logic              ls_tick;
    cmd_e              cmd;
    cfg_t              cfg;
    logic              unlocked;
    logic [CODE_W-1:0] code_shadow;
    logic [STAT_W-1:0] busy;
    logic              running;
    logic [CNT_W-1:0]  count;

    iwdg_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (ls_clk),
        .rise     (ls_tick)
    );

    iwdg_regs u_regs (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .addr        (addr),
        .wdata       (wdata),
        .ls_tick     (ls_tick),
        .cmd         (cmd),
        .cfg         (cfg),
        .unlocked    (unlocked),
        .code_shadow (code_shadow),
        .busy        (busy),
        .rdata       (rdata)
    );

    iwdg_core u_core (
        .clk     (clk),
        .rst     (rst),
        .ls_tick (ls_tick),
        .freeze  (dbg_freeze),
        .cmd     (cmd),
        .cfg     (cfg),
        .running (running),
        .count   (count),
        .fire    (wdg_reset)
    );

endmodule

// File: rtl/indep_watchdog_chk.sv
module indep_watchdog_chk
    import iwdg_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic              dbg_freeze,
    input logic              wdg_reset,
    input logic              ls_tick,
    input logic              running,
    input logic [CNT_W-1:0]  count,
    input logic              unlocked,
    input logic [CODE_W-1:0] code_shadow,
    input logic [STAT_W-1:0] busy
);
    p_pulse_width_r11: assert property (@(posedge clk) disable iff (rst)
        wdg_reset |=> !wdg_reset);

    p_run_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        running |=> running);

    p_fire_needs_start_r4: assert property (@(posedge clk) disable iff (rst)
        wdg_reset |-> $past(running));

    p_locked_write_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (addr == OFF_PRE) && !unlocked) |=> $stable(code_shadow));

    p_busy_clears_r8: assert property (@(posedge clk) disable iff (rst)
        (busy[BIT_PRE_BUSY] && ls_tick && !(wr_en && (addr == OFF_PRE)))
        |=> !busy[BIT_PRE_BUSY]);

    p_freeze_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (dbg_freeze && !wr_en) |=> $stable(count));

endmodule

bind indep_watchdog indep_watchdog_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .addr        (addr),
    .dbg_freeze  (dbg_freeze),
    .wdg_reset   (wdg_reset),
    .ls_tick     (ls_tick),
    .running     (running),
    .count       (count),
    .unlocked    (unlocked),
    .code_shadow (code_shadow),
    .busy        (busy)
);

// File: tb/test_indep_watchdog.sv
module test_indep_watchdog;

    localparam logic [4:0] A_KEY  = 5'h00;
    localparam logic [4:0] A_PRE  = 5'h04;
    localparam logic [4:0] A_RLD  = 5'h08;
    localparam logic [4:0] A_STAT = 5'h0C;
    localparam logic [4:0] A_WIN  = 5'h10;

    typedef struct {
        int    edge_idx;
        string req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ls_clk = 1'b0;
    logic        dbg_freeze = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  addr = '0;
    logic [31:0] wdata = '0;
    wire  [31:0] rdata;
    wire         wdg_reset;

    int   checks = 0;
    int   errors = 0;
    int   ls_edges = 0;
    int   ls_phase = 0;
    int   pulse_count = 0;
    logic prev_pulse = 1'b0;
    exp_t exp_q[$];

    indep_watchdog i_indep_watchdog (
        .clk        (clk),
        .rst        (rst),
        .ls_clk     (ls_clk),
        .dbg_freeze (dbg_freeze),
        .wr_en      (wr_en),
        .addr       (addr),
        .wdata      (wdata),
        .rdata      (rdata),
        .wdg_reset  (wdg_reset)
    );

    always #5 clk = ~clk;

    // low-speed clock: 8 clk cycles per period, edges counted by the bench
    always @(negedge clk) begin
        ls_phase <= (ls_phase == 7) ? 0 : ls_phase + 1;
        if (ls_phase == 7) begin
            ls_clk   <= 1'b1;
            ls_edges <= ls_edges + 1;
        end else if (ls_phase == 3) begin
            ls_clk <= 1'b0;
        end
    end

    // monitor: pair each reset pulse with the queued expectation
    always @(negedge clk) begin
        exp_t it;
        if (!rst) begin
            if (wdg_reset && !prev_pulse) begin
                pulse_count++;
                checks++;
                if (exp_q.size() == 0) begin
                    errors++;
                    $display("FAIL R4/R12: unexpected reset pulse at edge %0d, expected none", ls_edges);
                end else begin
                    it = exp_q.pop_front();
                    if (it.edge_idx != ls_edges) begin
                        errors++;
                        $display("FAIL %s: reset pulse at edge %0d, expected edge %0d",
                                 it.req, ls_edges, it.edge_idx);
                    end
                end
            end
            if (prev_pulse) begin
                checks++;
                if (wdg_reset) begin
                    errors++;
                    $display("FAIL R11: pulse width >1 cycle, actual high=%0d expected 0", wdg_reset);
                end
            end
        end
        prev_pulse <= wdg_reset && !rst;
    end

    task automatic check_eq(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: %s actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        addr  = a;
        wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [4:0] a, output int v);
        @(negedge clk);
        addr = a;
        #1;
        v = int'(rdata);
    endtask

    task automatic align();
        int s;
        s = ls_edges;
        while (ls_edges == s) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic push_exp(input int e, input string req);
        exp_t it;
        it.edge_idx = e;
        it.req      = req;
        exp_q.push_back(it);
    endtask

    task automatic wait_drain();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    function automatic int bdiv(input int code);
        return (code >= 6) ? 256 : (4 << code);
    endfunction

    task automatic setup_start(input int code, input int rld, input int win, output int e);
        do_reset();
        bus_wr(A_KEY, 32'h5555);
        bus_wr(A_PRE, 32'(code));
        bus_wr(A_RLD, 32'(rld));
        bus_wr(A_WIN, 32'(win));
        align();
        e = ls_edges;
        bus_wr(A_KEY, 32'hCCCC);
    endtask

    task automatic timeout_case(input int code, input int rld, input string req);
        int e;
        do_reset();
        bus_wr(A_KEY, 32'h5555);
        bus_wr(A_PRE, 32'(code));
        bus_wr(A_RLD, 32'(rld));
        align();
        e = ls_edges;
        push_exp(e + (rld + 1) * bdiv(code), req);
        bus_wr(A_KEY, 32'hCCCC);
        wait_drain();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete, actual hung expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int v;
        int e;
        int pc;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 defaults
        bus_rd(A_PRE, v);  check_eq("R1", "prescaler default", v, 0);
        bus_rd(A_RLD, v);  check_eq("R1", "reload default", v, 'hFFF);
        bus_rd(A_WIN, v);  check_eq("R1", "window default", v, 'hFFF);
        bus_rd(A_STAT, v); check_eq("R1", "status default", v, 0);

        // R2 locked write ignored, unlocked write taken
        bus_wr(A_PRE, 32'd3);
        bus_rd(A_PRE, v);  check_eq("R2", "locked prescaler write", v, 0);
        bus_wr(A_KEY, 32'h5555);
        bus_wr(A_PRE, 32'd5);
        bus_rd(A_PRE, v);  check_eq("R2", "unlocked prescaler write", v, 5);

        // R8 prescaler busy set then cleared by transfer
        bus_rd(A_STAT, v); check_eq("R8", "prescaler busy bit0 set", v & 1, 1);
        align();
        bus_rd(A_STAT, v); check_eq("R8", "prescaler busy cleared", v, 0);
        bus_wr(A_RLD, 32'd100);
        bus_rd(A_STAT, v); check_eq("R8", "reload busy bit1 set", v, 2);
        align();
        bus_rd(A_STAT, v); check_eq("R8", "reload busy cleared", v, 0);

        // R3 other key relocks
        bus_wr(A_KEY, 32'h1234);
        bus_wr(A_PRE, 32'd2);
        bus_rd(A_PRE, v);  check_eq("R3", "prescaler after relock", v, 5);
        bus_wr(A_WIN, 32'd7);
        bus_rd(A_WIN, v);  check_eq("R3", "window after relock", v, 'hFFF);

        // R12 reset restores defaults, stopped counter issues nothing
        do_reset();
        bus_rd(A_PRE, v);  check_eq("R12", "prescaler after block reset", v, 0);
        bus_rd(A_RLD, v);  check_eq("R12", "reload after block reset", v, 'hFFF);
        pc = pulse_count;
        repeat (30) align();
        check_eq("R12", "pulses while stopped", pulse_count, pc);

        // R4/R5 timeouts across prescaler codes
        timeout_case(0, 3, "R4");
        timeout_case(2, 1, "R5");
        timeout_case(7, 0, "R5");
        timeout_case(6, 1, "R5");

        // R6 feed restarts the full timeout
        setup_start(0, 3, 'hFFF, e);
        repeat (10) align();
        push_exp(ls_edges + 16, "R6");
        bus_wr(A_KEY, 32'hAAAA);
        wait_drain();

        // R7 key writes do not stop a running counter
        setup_start(1, 2, 'hFFF, e);
        push_exp(e + 24, "R7");
        bus_wr(A_KEY, 32'h0000);
        bus_wr(A_KEY, 32'h5555);
        bus_wr(A_KEY, 32'h1111);
        bus_wr(A_KEY, 32'hCCCC);
        wait_drain();

        // R9 early feed: counter 11 above window 10
        setup_start(0, 20, 10, e);
        repeat (36) align();
        push_exp(ls_edges, "R9");
        bus_wr(A_KEY, 32'hAAAA);
        wait_drain();

        // R9 boundary: counter 10 equals window 10, feed accepted
        setup_start(0, 20, 10, e);
        repeat (40) align();
        push_exp(ls_edges + 84, "R9");
        bus_wr(A_KEY, 32'hAAAA);
        wait_drain();

        // R10 freeze for 20 low-speed periods
        setup_start(0, 1, 'hFFF, e);
        push_exp(e + 28, "R10");
        dbg_freeze = 1'b1;
        repeat (20) align();
        dbg_freeze = 1'b0;
        wait_drain();

        do_reset();
        check_eq("R12", "outstanding expectations", exp_q.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule